// File: doc/BRIEF.md
# Doubling Multiply-Accumulate Unit

This block is the multiply and accumulate datapath of a small fixed-point DSP core. It holds two signed 16-bit operand registers, a 32-bit product register and a 32-bit accumulator. The product register always follows the operands. A write to either operand register reloads the product with the signed product of the operands, shifted left by one. A 32-bit result that does not fit wraps.

Three combined operations take two operands that the core has already fetched from data memory. Each one loads both operands into the operand registers and forms their doubled product. In the same step, it clears the accumulator, adds the previous product to it, or subtracts the previous product from it. The accumulator therefore always works with the product from the step before. This lets a core run a multiply-accumulate loop at one operation per cycle. Every accumulator update refreshes the negative, overflow and zero flags.

Top module: `mac_unit`

## Requirements
- R1: While reset is held low, the two operand outputs, the product and the accumulator are all zero. The negative and overflow flags are clear and the zero flag is set.
- R2: On opSel = 1, the clock edge loads wrData into the X register. The product register loads 2·wrData·Y, using the Y value held before that edge. The accumulator and the flags do not change.
- R3: On opSel = 2, the clock edge loads wrData into the Y register. The product register loads 2·X·wrData, using the X value held before that edge. The accumulator and the flags do not change.
- R4: The product is the signed 16×16 product doubled and truncated to 32 bits. For example, −32768 × −32768 gives 0x80000000.
- R5: On opSel = 3 (clear-multiply), X takes memOpJ, Y takes memOpI and the product register takes 2·memOpJ·memOpI. The accumulator becomes zero.
- R6: On opSel = 4 (multiply-add), the operands and product load as in R5. The accumulator becomes its old value plus the product held before the edge, modulo 2^32.
- R7: On opSel = 5 (multiply-subtract), the operands and product load as in R5. The accumulator becomes its old value minus the product held before the edge, modulo 2^32.
- R8: After every accumulator update, the overflow flag is set exactly when the signed result is outside the 32-bit signed range. A clear-multiply clears the flag.
- R9: After every accumulator update, the negative flag equals bit 31 of the accumulator and the zero flag is set exactly when the accumulator is zero. Without an accumulator update, all three flags hold their values.
- R10: opSel values 0, 6 and 7 change no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opSel | input | 3 | Operation select: 0 idle, 1 write X, 2 write Y, 3 clear-multiply, 4 multiply-add, 5 multiply-subtract, 6/7 ignored |
| wrData | input | 16 | Data for the operand-register writes |
| memOpJ | input | 16 | First memory operand (goes to X) |
| memOpI | input | 16 | Second memory operand (goes to Y) |
| xOut | output | 16 | X operand register |
| yOut | output | 16 | Y operand register |
| prodOut | output | 32 | Product register |
| accOut | output | 32 | Accumulator |
| flagNeg | output | 1 | Negative flag |
| flagOvf | output | 1 | Overflow flag |
| flagZero | output | 1 | Zero flag |

## Verification
A directed opening sequence writes X and Y alone. This shows that the product uses the new value of one operand and the held value of the other. The sequence then runs add and subtract steps whose results visibly differ depending on whether the old or the new product is used. The most-negative operand pair is driven and then subtracted from zero. This separates correct 32-bit wrap and overflow detection from a sign-extended or saturating result. A long run of random operations follows, including the two ignored codes and extreme operands. It is compared cycle by cycle against a behavioural model, which exposes flags that are updated or held at the wrong time.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {ACC_HOLD, ACC_CLEAR, ACC_ADD, ACC_SUB} acc_mode_t;

  typedef struct packed {
    logic      ldX;
    logic      ldY;
    logic      ldPair;
    acc_mode_t accMode;
  } mac_strobe_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  opSel,
  output mac_strobe_t strobe
);
  always_comb begin
    strobe = '0;
    strobe.accMode = ACC_HOLD;
    unique case (opSel)
      3'd1: strobe.ldX = 1'b1;
      3'd2: strobe.ldY = 1'b1;
      3'd3: begin strobe.ldPair = 1'b1; strobe.accMode = ACC_CLEAR; end
      3'd4: begin strobe.ldPair = 1'b1; strobe.accMode = ACC_ADD;   end
      3'd5: begin strobe.ldPair = 1'b1; strobe.accMode = ACC_SUB;   end
      default: ;
    endcase
  end

  // At most one load strobe per step (R2, R3, R5)
  p_single_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ldX, strobe.ldY, strobe.ldPair}));

  // Paired load and accumulator activity go together (R10)
  p_acc_needs_pair_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accMode != ACC_HOLD) == strobe.ldPair);
endmodule

// File: rtl/mac_dpath.sv
module mac_dpath
  import mac_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  mac_strobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memOpJ,
  input  logic [DATA_W-1:0] memOpI,
  output logic [DATA_W-1:0] xReg,
  output logic [DATA_W-1:0] yReg,
  output logic [ACC_W-1:0]  pReg,
  output logic [ACC_W-1:0]  aReg,
  output logic              nFlag,
  output logic              vFlag,
  output logic              zFlag
);
  logic [DATA_W-1:0]        mulA, mulB;
  logic signed [ACC_W-1:0]  fullProd;
  logic [ACC_W-1:0]         newProd;
  logic [ACC_W:0]           sumExt;
  logic [ACC_W-1:0]         nextAcc;
  logic                     nextOvf;
  logic                     accUpd;

  // Operand select: the new value of a written register, the held value of the other
  always_comb begin
    mulA = xReg;
    mulB = yReg;
    if (strobe.ldPair) begin
      mulA = memOpJ;
      mulB = memOpI;
    end else begin
      if (strobe.ldX) mulA = wrData;
      if (strobe.ldY) mulB = wrData;
    end
  end

  assign fullProd = $signed(mulA) * $signed(mulB);
  assign newProd  = {fullProd[ACC_W-2:0], 1'b0};

  // Accumulator adder with one guard bit for overflow detection
  always_comb begin
    sumExt  = '0;
    nextAcc = aReg;
    nextOvf = vFlag;
    unique case (strobe.accMode)
      ACC_CLEAR: begin nextAcc = '0; nextOvf = 1'b0; end
      ACC_ADD: begin
        sumExt  = {aReg[ACC_W-1], aReg} + {pReg[ACC_W-1], pReg};
        nextAcc = sumExt[ACC_W-1:0];
        nextOvf = sumExt[ACC_W] ^ sumExt[ACC_W-1];
      end
      ACC_SUB: begin
        sumExt  = {aReg[ACC_W-1], aReg} - {pReg[ACC_W-1], pReg};
        nextAcc = sumExt[ACC_W-1:0];
        nextOvf = sumExt[ACC_W] ^ sumExt[ACC_W-1];
      end
      default: ;
    endcase
  end

  assign accUpd = (strobe.accMode != ACC_HOLD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xReg  <= '0;
      yReg  <= '0;
      pReg  <= '0;
      aReg  <= '0;
      nFlag <= 1'b0;
      vFlag <= 1'b0;
      zFlag <= 1'b1;
    end else begin
      if (strobe.ldX || strobe.ldPair) xReg <= mulA;
      if (strobe.ldY || strobe.ldPair) yReg <= mulB;
      if (strobe.ldX || strobe.ldY || strobe.ldPair) pReg <= newProd;
      if (accUpd) begin
        aReg  <= nextAcc;
        vFlag <= nextOvf;
        nFlag <= nextAcc[ACC_W-1];
        zFlag <= (nextAcc == '0);
      end
    end
  end

  // Product register always tracks the doubled operand product (R4)
  p_prod_tracks_r4: assert property (@(posedge clk) disable iff (!rstN)
    pReg == ACC_W'(($signed(xReg) * $signed(yReg)) * 2));

  // Accumulator and flags hold without an accumulator operation (R9)
  p_hold_acc_r9: assert property (@(posedge clk) disable iff (!rstN)
    !accUpd |=> $stable(aReg) && $stable({nFlag, vFlag, zFlag}));

  // Clear-multiply empties the accumulator (R5)
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accMode == ACC_CLEAR |=> aReg == '0 && zFlag && !vFlag && !nFlag);

  // Add overflow: same-sign inputs with a result of the other sign (R8)
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accMode == ACC_ADD |=> vFlag ==
      (($past(aReg[ACC_W-1]) == $past(pReg[ACC_W-1])) && (aReg[ACC_W-1] != $past(aReg[ACC_W-1]))));

  // Flag consistency with accumulator value (R9)
  p_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    nFlag == aReg[ACC_W-1] && zFlag == (aReg == '0));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memOpJ,
  input  logic [DATA_W-1:0] memOpI,
  output logic [DATA_W-1:0] xOut,
  output logic [DATA_W-1:0] yOut,
  output logic [ACC_W-1:0]  prodOut,
  output logic [ACC_W-1:0]  accOut,
  output logic              flagNeg,
  output logic              flagOvf,
  output logic              flagZero
);
  mac_strobe_t strobe;

  mac_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .opSel(opSel), .strobe(strobe)
  );

  mac_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(wrData), .memOpJ(memOpJ), .memOpI(memOpI),
    .xReg(xOut), .yReg(yOut), .pReg(prodOut), .aReg(accOut),
    .nFlag(flagNeg), .vFlag(flagOvf), .zFlag(flagZero)
  );
endmodule

// File: tb/mac_unit_tb.sv
module mac_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opSel = '0;
  logic [15:0] wrData = '0, memOpJ = '0, memOpI = '0;
  logic [15:0] xOut, yOut;
  logic [31:0] prodOut, accOut;
  logic        flagNeg, flagOvf, flagZero;

  int checks = 0;
  int failures = 0;

  // reference state
  logic [15:0] mX, mY;
  logic [31:0] mP, mA;
  logic        mN, mV, mZ;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_unit dut_i (
    .clk(clk), .rstN(rstN), .opSel(opSel), .wrData(wrData),
    .memOpJ(memOpJ), .memOpI(memOpI), .xOut(xOut), .yOut(yOut),
    .prodOut(prodOut), .accOut(accOut), .flagNeg(flagNeg),
    .flagOvf(flagOvf), .flagZero(flagZero)
  );

  function automatic logic [31:0] dbl(input logic [15:0] a, input logic [15:0] b);
    longint pa = longint'($signed(a));
    longint pb = longint'($signed(b));
    longint r = pa * pb * 2;
    return r[31:0];
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelStep(input logic [2:0] op, input logic [15:0] d, input logic [15:0] j, input logic [15:0] i);
    longint s;
    logic [31:0] oldP = mP;
    case (op)
      3'd1: begin mX = d; mP = dbl(mX, mY); end
      3'd2: begin mY = d; mP = dbl(mX, mY); end
      3'd3, 3'd4, 3'd5: begin
        mX = j; mY = i; mP = dbl(j, i);
        if (op == 3'd3) s = 0;
        else if (op == 3'd4) s = longint'($signed(mA)) + longint'($signed(oldP));
        else s = longint'($signed(mA)) - longint'($signed(oldP));
        mV = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        mA = s[31:0];
        mN = mA[31];
        mZ = (mA == 0);
      end
      default: ;
    endcase
  endtask

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic compareAll(input string tag);
    chk(tag, "x", xOut, mX);
    chk(tag, "y", yOut, mY);
    chk(tag, "p", prodOut, mP);
    chk(tag, "acc", accOut, mA);
    chk("R9", "neg", flagNeg, mN);
    chk("R9", "zero", flagZero, mZ);
    chk("R8", "ovf", flagOvf, mV);
  endtask

  // drive at negedge, model update, compare at next negedge
  task automatic step(input logic [2:0] op, input logic [15:0] d, input logic [15:0] j, input logic [15:0] i);
    opSel = op; wrData = d; memOpJ = j; memOpI = i;
    modelStep(op, d, j, i);
    @(negedge clk);
    compareAll(tagOf(op));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mX = 0; mY = 0; mP = 0; mA = 0; mN = 0; mV = 0; mZ = 1;
    repeat (3) @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    step(3'd1, 16'd3, 16'h0, 16'h0);           // R2: Y=0 -> P=0
    step(3'd2, 16'hFFFB, 16'h0, 16'h0);        // R3: P = 2*3*-5
    chk("R3", "p=-30", prodOut, 32'hFFFFFFE2);
    step(3'd4, 16'h0, 16'd100, 16'd200);       // R6: A += -30
    chk("R6", "acc old product", accOut, 32'hFFFFFFE2);
    step(3'd5, 16'h0, 16'd7, 16'd1);           // R7: A -= 40000
    step(3'd6, 16'h1234, 16'h5555, 16'h6666);  // R10
    step(3'd7, 16'h4321, 16'h1, 16'h1);        // R10
    step(3'd0, 16'hFFFF, 16'hFFFF, 16'hFFFF);  // R10
    step(3'd3, 16'h0, 16'h8000, 16'h8000);     // R5 + R4 corner
    chk("R4", "min*min doubled", prodOut, 32'h80000000);
    chk("R5", "acc cleared", accOut, 32'h0);
    step(3'd5, 16'h0, 16'd1, 16'd1);           // R8: 0 - (-2^31) overflows
    chk("R8", "ovf set", flagOvf, 1'b1);
    chk("R7", "wrap", accOut, 32'h80000000);
    step(3'd1, 16'h7FFF, 16'h0, 16'h0);        // R2 flags held
    chk("R9", "ovf held", flagOvf, 1'b1);
    step(3'd3, 16'h0, 16'h7FFF, 16'h7FFF);     // R8 cleared
    chk("R8", "ovf cleared", flagOvf, 1'b0);

    for (int k = 0; k < 3000; k++) begin
      logic [15:0] d, j, i;
      d = 16'($urandom);
      j = (k % 7 == 0) ? 16'h8000 : 16'($urandom);
      i = (k % 11 == 0) ? 16'h7FFF : 16'($urandom);
      step(3'($urandom_range(0, 7)), d, j, i);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule